// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block holds the VLAN membership table of a small Ethernet switch. It has a fixed number of entries, 16 by default. Each entry pairs a 12-bit VLAN ID with a 10-bit port member mask. The table is never written directly. The host first puts a member mask into a staging data register, then writes a command word that carries an opcode, a VLAN ID, a port number and a start bit. While the command runs, the engine holds its busy flag high. The flag drops by itself when the command is done.

Four commands change the table:
- **Clear all** empties the table one entry per cycle.
- **Insert** creates or replaces the entry for a VLAN ID.
- **Delete** removes the entry for a single VLAN ID.
- **Strip port** takes one port out of the member mask of every entry.

A separate combinational lookup port is used by the forwarding logic. It takes a VLAN ID and returns the member mask of the matching entry together with a hit flag.

The host interface is a single-cycle write strobe with a word address and a combinational read mux. Word address 0 selects the command word and address 1 selects the staging data register.

Top module: `vtab_engine`

## Requirements
- R1: After reset, busy is low, both host words read as zero and every lookup misses.
- R2: The command word has this layout:
  - bits 2:0 opcode: 0 idle, 1 clear all, 2 insert, 3 delete, 4 strip port; 5 to 7 act as idle.
  - bit 3 start/active.
  - bit 4 table-full.
  - bits 11:8 port number.
  - bits 27:16 VLAN ID.
  - bits 30:28 priority.
  - bit 31 priority enable.

  A write with bit 3 set while idle starts the command. Bit 3 and `busy` read 1 until the command ends. A write with bit 3 clear only stores the fields.
- R3: The staging data word keeps a member mask in bits 9:0 and a valid bit in bit 11. All other bits read 0.
- R4: An insert of a VLAN ID not yet in the table takes a free entry when one exists. A later lookup of that ID hits and returns the staged mask.
- R5: An insert of a VLAN ID already in the table replaces that entry's mask and does not use a second entry.
- R6: An insert that finds no free entry leaves the table unchanged and sets bit 4. The next started command clears bit 4.
- R7: A delete invalidates only the entry whose VLAN ID matches.
- R8: A strip-port command clears the given port's bit in the mask of every entry. A port number of 10 or more changes nothing.
- R9: A clear-all command keeps `busy` high for exactly DEPTH cycles and leaves every entry invalid.
- R10: A command-word write that arrives while `busy` is high is ignored.
- R11: A lookup that misses returns a zero mask with the hit flag low.
- R12: Idle, insert, delete and strip-port commands keep `busy` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 1 | Word select: 0 command, 1 staging data |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Read data of the selected word |
| lkVid | input | 12 | Lookup VLAN ID |
| lkHit | output | 1 | Lookup found a valid matching entry |
| lkMask | output | 10 | Member mask of the matching entry |
| busy | output | 1 | A command is in progress |

## Verification
The assertions assume two things about the inputs:
- A command write counts as a start only when bit 3 of the write data is set.
- The lookup VLAN ID is held steady across a clock edge whenever the stability property is meant to apply.

The property that the lookup result is stable is therefore qualified by a steady `lkVid` and by the absence of a command finishing. The stimulus changes `lkVid` only between edges. It issues every command through a task that waits for `busy` to fall, except in the one scenario that deliberately writes during a clear-all to exercise R10.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int VID_W  = 12;
  localparam int MASK_W = 10;
  localparam int PORT_W = 4;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_INSERT = 3'd2,
    OP_DELETE = 3'd3,
    OP_STRIP = 3'd4
  } vtabOp_e;

  typedef struct packed {
    logic valid;
    logic [VID_W-1:0] vid;
    logic [MASK_W-1:0] mask;
  } vtabEntry_t;

  typedef struct packed {
    logic doInsert;
    logic doDelete;
    logic doStrip;
    logic doClear;
  } vtabStrb_t;
endpackage

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  vtabStrb_t strb,
  input  logic [IDX_W-1:0] clrIdx,
  input  logic [VID_W-1:0] opVid,
  input  logic [PORT_W-1:0] opPort,
  input  logic [MASK_W-1:0] opMask,
  input  logic [VID_W-1:0] lkVid,
  output logic lkHit,
  output logic [MASK_W-1:0] lkMask,
  output logic noRoom
);
  vtabEntry_t entArr [DEPTH];

  logic matchAny, freeAny;
  logic [IDX_W-1:0] matchIdx, freeIdx;
  logic [MASK_W-1:0] keepMask;

  // Lowest-index match and lowest-index free slot for the command VLAN ID.
  always_comb begin
    matchAny = 1'b0;
    freeAny  = 1'b0;
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (entArr[i].valid && entArr[i].vid == opVid) begin
        matchAny = 1'b1;
        matchIdx = IDX_W'(i);
      end
      if (!entArr[i].valid) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign noRoom   = !matchAny && !freeAny;
  // A port number past the mask width shifts out and keeps every bit.
  assign keepMask = ~(MASK_W'(1) << opPort);

  always_comb begin
    lkHit  = 1'b0;
    lkMask = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (entArr[i].valid && entArr[i].vid == lkVid) begin
        lkHit  = 1'b1;
        lkMask = entArr[i].mask;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    vtabEntry_t ent;
    logic insSel;
    assign insSel = strb.doInsert &&
                    (matchAny ? (matchIdx == IDX_W'(g)) : (freeAny && freeIdx == IDX_W'(g)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent <= '0;
      end else if (strb.doClear && clrIdx == IDX_W'(g)) begin
        ent.valid <= 1'b0;
      end else if (insSel) begin
        ent.valid <= 1'b1;
        ent.vid   <= opVid;
        ent.mask  <= opMask;
      end else if (strb.doDelete && matchAny && matchIdx == IDX_W'(g)) begin
        ent.valid <= 1'b0;
      end else if (strb.doStrip) begin
        ent.mask <= ent.mask & keepMask;
      end
    end

    assign entArr[g] = ent;
  end
endmodule

// File: rtl/vtab_ctrl.sv
module vtab_ctrl
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdWr,
  input  logic [31:0] cmdData,
  input  logic noRoom,
  output logic busy,
  output logic [31:0] cmdRead,
  output vtabStrb_t strb,
  output logic [IDX_W-1:0] clrIdx,
  output logic [VID_W-1:0] opVid,
  output logic [PORT_W-1:0] opPort
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_CLEAR} ctrlState_e;

  ctrlState_e state;
  vtabOp_e opReg;
  logic [2:0] prioReg;
  logic prioEnReg, fullReg;
  logic [IDX_W-1:0] idxReg;
  logic accept;

  assign busy   = (state != ST_IDLE);
  assign accept = cmdWr && !busy;
  assign clrIdx = idxReg;

  always_comb begin
    strb = '0;
    if (state == ST_EXEC) begin
      strb.doInsert = (opReg == OP_INSERT);
      strb.doDelete = (opReg == OP_DELETE);
      strb.doStrip  = (opReg == OP_STRIP);
    end
    if (state == ST_CLEAR) strb.doClear = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opReg     <= OP_IDLE;
      prioReg   <= '0;
      prioEnReg <= 1'b0;
      fullReg   <= 1'b0;
      idxReg    <= '0;
      opVid     <= '0;
      opPort    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          opReg     <= vtabOp_e'(cmdData[2:0]);
          opPort    <= cmdData[11:8];
          opVid     <= cmdData[27:16];
          prioReg   <= cmdData[30:28];
          prioEnReg <= cmdData[31];
          idxReg    <= '0;
          if (cmdData[3]) begin
            fullReg <= 1'b0;
            state   <= (cmdData[2:0] == 3'(OP_CLEAR)) ? ST_CLEAR : ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (opReg == OP_INSERT && noRoom) fullReg <= 1'b1;
          state <= ST_IDLE;
        end
        ST_CLEAR: begin
          if (idxReg == IDX_W'(DEPTH - 1)) state <= ST_IDLE;
          else idxReg <= idxReg + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmdRead = {prioEnReg, prioReg, opVid, 4'b0000, opPort, 3'b000, fullReg, busy, 3'(opReg)};
endmodule

// File: rtl/vtab_engine.sv
module vtab_engine
  import vtab_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostWr,
  input  logic hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  input  logic [11:0] lkVid,
  output logic lkHit,
  output logic [9:0] lkMask,
  output logic busy
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [MASK_W-1:0] stageMask;
  logic stageValid;
  logic [31:0] cmdRead;
  vtabStrb_t strb;
  logic [IDX_W-1:0] clrIdx;
  logic [VID_W-1:0] opVid;
  logic [PORT_W-1:0] opPort;
  logic noRoom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageMask  <= '0;
      stageValid <= 1'b0;
    end else if (hostWr && hostAddr) begin
      stageMask  <= hostWrData[MASK_W-1:0];
      stageValid <= hostWrData[11];
    end
  end

  vtab_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWr(hostWr && !hostAddr), .cmdData(hostWrData), .noRoom(noRoom),
    .busy(busy), .cmdRead(cmdRead), .strb(strb), .clrIdx(clrIdx),
    .opVid(opVid), .opPort(opPort)
  );

  vtab_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .clrIdx(clrIdx),
    .opVid(opVid), .opPort(opPort), .opMask(stageMask),
    .lkVid(lkVid), .lkHit(lkHit), .lkMask(lkMask), .noRoom(noRoom)
  );

  assign hostRdData = hostAddr ? {20'b0, stageValid, 1'b0, stageMask} : cmdRead;
endmodule

// File: rtl/vtab_engine_chk.sv
module vtab_engine_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rstN,
  input logic hostWr,
  input logic hostAddr,
  input logic [31:0] hostWrData,
  input logic busy,
  input logic [11:0] lkVid,
  input logic lkHit,
  input logic [9:0] lkMask
);
  localparam int RUN_W = $clog2(DEPTH + 2) + 1;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else busyRun <= '0;
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && !hostAddr && hostWrData[3] && !busy |=> busy);

  assert_nostart_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && !hostAddr && !hostWrData[3] && !busy |=> !busy);

  assert_single_cycle_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) && $past(hostWrData[2:0]) != 3'd1 |=> !busy);

  assert_clear_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(DEPTH));

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> lkMask == '0);

  assert_lookup_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !$past(busy) && $stable(lkVid) |-> $stable(lkHit) && $stable(lkMask));
endmodule

bind vtab_engine vtab_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .busy(busy), .lkVid(lkVid), .lkHit(lkHit), .lkMask(lkMask)
);

// File: tb/vtab_engine_tb.sv
module vtab_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0;
  logic hostAddr = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [11:0] lkVid = '0;
  logic lkHit;
  logic [9:0] lkMask;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vtab_engine #(.DEPTH(16)) u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .lkVid(lkVid), .lkHit(lkHit), .lkMask(lkMask), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [2:0] op, input logic [11:0] vid,
                                        input logic [3:0] port, input bit start);
    return {4'b0000, vid, 4'b0000, port, 3'b000, 1'b0, start, op};
  endfunction

  task automatic wrReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic runCmd(input logic [31:0] cmd, output int busyCycles);
    wrReg(1'b0, cmd);
    busyCycles = 0;
    while (busy) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic insert(input logic [11:0] vid, input logic [9:0] mask);
    int n;
    wrReg(1'b1, {20'b0, 1'b1, 1'b0, mask});
    runCmd(mkCmd(3'd2, vid, 4'd0, 1'b1), n);
  endtask

  task automatic look(input logic [11:0] vid, input string req, input bit expHit, input logic [9:0] expMask);
    lkVid = vid;
    #1;
    check(lkHit == expHit && lkMask == expMask, req, {21'b0, lkHit, lkMask}, {21'b0, expHit, expMask});
  endtask

  task automatic readWord(input logic a, output logic [31:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(busy == 1'b0, "R1 busy", 32'(busy), 0);
    readWord(1'b0, d); check(d == 0, "R1 cmd word", d, 0);
    readWord(1'b1, d); check(d == 0, "R1 data word", d, 0);
    look(12'h000, "R1 lookup miss", 1'b0, 10'h000);
  endtask

  task automatic t_stage;
    logic [31:0] d;
    wrReg(1'b1, 32'hFFFF_FFFF);
    readWord(1'b1, d); check(d == 32'h0000_0BFF, "R3 data layout", d, 32'h0000_0BFF);
  endtask

  task automatic t_insert;
    int n;
    logic [31:0] d;
    wrReg(1'b1, 32'h0000_080A);
    // Priority fields ride along: enable bit 31 and priority 5 in bits 30:28.
    runCmd(mkCmd(3'd2, 12'h123, 4'd6, 1'b1) | 32'hD000_0000, n);
    check(n == 1, "R12 insert busy cycles", n, 1);
    look(12'h123, "R4 new entry", 1'b1, 10'h00A);
    look(12'h124, "R11 miss", 1'b0, 10'h000);
    readWord(1'b0, d);
    check(d == 32'hD123_0602, "R2 cmd readback", d, 32'hD123_0602);
    // Write with start clear: fields stored, nothing runs.
    wrReg(1'b0, mkCmd(3'd1, 12'h456, 4'd2, 1'b0));
    check(busy == 1'b0, "R2 no start", 32'(busy), 0);
    readWord(1'b0, d);
    check(d == 32'h0456_0201, "R2 fields only", d, 32'h0456_0201);
    look(12'h123, "R2 table kept", 1'b1, 10'h00A);
  endtask

  task automatic t_overwrite;
    insert(12'h123, 10'h3F0);
    look(12'h123, "R5 replaced mask", 1'b1, 10'h3F0);
  endtask

  task automatic t_full;
    logic [31:0] d;
    int n;
    for (int i = 0; i < 15; i++) insert(12'h200 + 12'(i), 10'h008 | 10'(i << 4));
    look(12'h20E, "R4 last slot", 1'b1, 10'h0E8);
    insert(12'h7FF, 10'h15D);
    readWord(1'b0, d); check(d[4] == 1'b1, "R6 full flag set", d, d | 32'h10);
    look(12'h7FF, "R6 no entry made", 1'b0, 10'h000);
    look(12'h123, "R6 table kept", 1'b1, 10'h3F0);
    runCmd(mkCmd(3'd0, 12'h000, 4'd0, 1'b1), n);
    check(n == 1, "R12 idle busy cycles", n, 1);
    readWord(1'b0, d); check(d[4] == 1'b0, "R6 full flag cleared", d, d & ~32'h10);
  endtask

  task automatic t_delete;
    int n;
    logic [31:0] d;
    runCmd(mkCmd(3'd3, 12'h205, 4'd0, 1'b1), n);
    check(n == 1, "R12 delete busy cycles", n, 1);
    look(12'h205, "R7 deleted", 1'b0, 10'h000);
    look(12'h206, "R7 neighbour kept", 1'b1, 10'h068);
    insert(12'h7FF, 10'h15D);
    look(12'h7FF, "R4 reuses freed slot", 1'b1, 10'h15D);
    readWord(1'b0, d); check(d[4] == 1'b0, "R6 no full", d, d & ~32'h10);
  endtask

  task automatic t_strip;
    int n;
    runCmd(mkCmd(3'd4, 12'h000, 4'd3, 1'b1), n);
    check(n == 1, "R12 strip busy cycles", n, 1);
    look(12'h200, "R8 port 3 stripped", 1'b1, 10'h000);
    look(12'h20E, "R8 port 3 stripped", 1'b1, 10'h0E0);
    look(12'h7FF, "R8 port 3 stripped", 1'b1, 10'h155);
    look(12'h123, "R8 other bits kept", 1'b1, 10'h3F0);
    runCmd(mkCmd(3'd4, 12'h000, 4'd12, 1'b1), n);
    look(12'h123, "R8 port 12 no effect", 1'b1, 10'h3F0);
    look(12'h7FF, "R8 port 12 no effect", 1'b1, 10'h155);
  endtask

  task automatic t_clear;
    int n;
    logic [31:0] d;
    wrReg(1'b1, 32'h0000_0BFF);
    wrReg(1'b0, mkCmd(3'd1, 12'h000, 4'd0, 1'b1));
    n = 0;
    while (busy) begin
      n++;
      if (n == 3) begin
        hostWr = 1'b1; hostAddr = 1'b0; hostWrData = mkCmd(3'd2, 12'h333, 4'd1, 1'b1);
      end else begin
        hostWr = 1'b0;
      end
      @(negedge clk);
    end
    hostWr = 1'b0;
    check(n == 16, "R9 clear busy cycles", n, 16);
    readWord(1'b0, d);
    check(d == 32'h0000_0001, "R10 cmd word unchanged", d, 32'h0000_0001);
    look(12'h333, "R10 ignored insert", 1'b0, 10'h000);
    look(12'h123, "R9 cleared", 1'b0, 10'h000);
    look(12'h20F - 12'h001, "R9 cleared", 1'b0, 10'h000);
    look(12'h7FF, "R9 cleared", 1'b0, 10'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_insert();
    t_overwrite();
    t_full();
    t_delete();
    t_strip();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule